// File: doc/BRIEF.md
# Reduced-Gigabit Receive Link Status Resolver

This block watches the receive side of a reduced gigabit media interface and works out the link state the MAC should run with: link up or down, line rate (10, 100 or 1000 Mb/s) and duplex. Between frames, the PHY places a status nibble on RXD. The block captures that nibble only while the receive control line is low on both clock edges. It filters the nibble for glitches and decodes it.

A control word chooses the source of the result. In in-band mode the result comes from the decoded nibble. In forced mode it comes from the gigabit enable, full-duplex enable and fast-speed select bits. A separate pin says whether the port is the reduced gigabit interface or the 10/100 reduced interface (RMII).

On the reduced gigabit interface, forced mode has no way to reach 10 Mb/s. A forced 10 Mb/s request there, and any other setting the MAC cannot honour, raises an unsupported flag and holds the link down. Every change of the resolved state produces a one-cycle strobe. All pins are plain level signals: the block carries no data stream, so there is no handshake and no back-pressure.

Top module: `rgmii_link_resolver`

## Requirements
- R1: While reset is active, and until a new result is resolved, the outputs read link down, speed code 00 (10 Mb/s), half duplex, with status_chg, code_err and cfg_unsupported low.
- R2: A nibble is a capture candidate only on cycles where both rx_ctl_rise and rx_ctl_fall are 0. RXD values present while either is 1 never change the result.
- R3: The nibble is decoded as follows:
  - bit 0 is link (1 = up);
  - bits 2:1 are the clock code: 00 = 10 Mb/s, 01 = 100 Mb/s, 10 = 1000 Mb/s;
  - bit 3 is duplex (1 = full).
  The decoded state updates when the same nibble is sampled idle on two consecutive rising edges. With in-band mode selected, the outputs show it after the next edge. link_speed uses the same 00/01/10 code.
- R4: A nibble that is present on only one idle sample, with a different value before and after it, has no effect on the outputs.
- R5: Clock code 11 is reserved. A stable reserved nibble leaves the decoded state unchanged and holds code_err at 1. code_err is 0 on cycles where the last stable idle nibble carried a legal code or no stable idle nibble was seen.
- R6: When ctl_inband_en is 0, the result comes from the forced bits. On the reduced gigabit interface (rmii_sel = 0), ctl_gig_en = 1 selects 1000 Mb/s, and duplex always follows ctl_fdx_en.
- R7: In forced mode on RMII (rmii_sel = 1), ctl_fast_sel selects the speed: 0 gives 10 Mb/s and 1 gives 100 Mb/s.
- R8: In forced mode on the reduced gigabit interface without ctl_gig_en, ctl_fast_sel = 1 gives 100 Mb/s. ctl_fast_sel = 0 is a 10 Mb/s request; it raises cfg_unsupported and the link reads down.
- R9: cfg_unsupported is also raised, with the link down, in four other cases:
  - gigabit is selected with half duplex;
  - ctl_gig_en is set on RMII;
  - in-band mode is selected on RMII;
  - the decoded in-band state is 1000 Mb/s half duplex.
  In forced mode, when the configuration is supported, the link is up.
- R10: status_chg is 1 for exactly the cycle in which link_up, link_speed, full_duplex or cfg_unsupported differ from the previous cycle, and 0 otherwise.
- R11: A configuration change reaches the outputs after one rising edge. The decoded in-band state is kept while forced mode is active and is used again when in-band mode returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_ctl_rise | input | 1 | Receive control sampled on the rising edge (data valid) |
| rx_ctl_fall | input | 1 | Receive control sampled on the falling edge (error term) |
| rxd | input | 4 | Receive data nibble |
| ctl_inband_en | input | 1 | 1 = take status from in-band nibbles, 0 = forced bits |
| ctl_gig_en | input | 1 | Forced 1000 Mb/s request |
| ctl_fdx_en | input | 1 | Forced full duplex request |
| ctl_fast_sel | input | 1 | Forced speed select: 0 = 10 Mb/s, 1 = 100 Mb/s |
| rmii_sel | input | 1 | Interface type: 0 = reduced gigabit, 1 = RMII |
| link_up | output | 1 | Resolved link state |
| link_speed | output | 2 | Resolved speed: 00 = 10, 01 = 100, 10 = 1000 Mb/s |
| full_duplex | output | 1 | Resolved duplex |
| status_chg | output | 1 | One-cycle strobe on any resolved state change |
| code_err | output | 1 | Stable in-band nibble carries the reserved clock code |
| cfg_unsupported | output | 1 | The current configuration cannot be honoured |

## Verification
The assertions cover the properties that must hold on every cycle:
- the decoded state moves only after two idle samples and never takes the reserved speed code;
- a reserved code leaves the decoded state untouched;
- a flagged configuration always reads link down;
- a gigabit link is always full duplex;
- the change strobe matches the output movement exactly.

Only the bench scenarios can show the rest:
- the exact two-sample latency of the filter;
- that a single-cycle glitch or a nibble under active receive control is ignored;
- the full decode of all sixteen nibbles;
- the result of every forced bit combination;
- that in-band state is retained across a mode switch.

// File: rtl/rgmii_link_pkg.sv
package rgmii_link_pkg;
  localparam int NIB_W  = 4;
  localparam int CODE_W = 2;

  typedef enum logic [CODE_W-1:0] {
    SPD_10   = 2'b00,
    SPD_100  = 2'b01,
    SPD_1000 = 2'b10,
    SPD_RSVD = 2'b11
  } speed_e;

  typedef struct packed {
    logic   link;
    speed_e spd;
    logic   fdx;
    logic   unsup;
  } link_state_t;
endpackage

// File: rtl/rgmii_inband_capture.sv
module rgmii_inband_capture
  import rgmii_link_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_rise,
  input  logic             ctl_fall,
  input  logic [NIB_W-1:0] nib,
  output logic             dec_link,
  output speed_e           dec_spd,
  output logic             dec_fdx,
  output logic             rsvd_seen
);
  logic             idle;
  logic             prev_idle;
  logic [NIB_W-1:0] prev_nib;
  logic             stable_hit;

  assign idle       = !ctl_rise && !ctl_fall;
  assign stable_hit = idle && prev_idle && (nib == prev_nib);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_idle <= 1'b0;
      prev_nib  <= '0;
      dec_link  <= 1'b0;
      dec_spd   <= SPD_10;
      dec_fdx   <= 1'b0;
      rsvd_seen <= 1'b0;
    end else begin
      prev_idle <= idle;
      prev_nib  <= nib;
      rsvd_seen <= 1'b0;
      if (stable_hit) begin
        if (speed_e'(nib[2:1]) == SPD_RSVD) begin
          rsvd_seen <= 1'b1;
        end else begin
          dec_link <= nib[0];
          dec_spd  <= speed_e'(nib[2:1]);
          dec_fdx  <= nib[3];
        end
      end
    end
  end

  // R2
  capture_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(idle && prev_idle) |=> $stable({dec_link, dec_spd, dec_fdx}));

  // R3
  legal_speed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_spd != SPD_RSVD);

  // R5
  rsvd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_seen |-> $stable({dec_link, dec_spd, dec_fdx}));
endmodule

// File: rtl/rgmii_forced_cfg.sv
module rgmii_forced_cfg
  import rgmii_link_pkg::*;
(
  input  logic   gig_en,
  input  logic   fdx_en,
  input  logic   fast_sel,
  input  logic   rmii,
  output speed_e spd,
  output logic   fdx,
  output logic   unsup
);
  always_comb begin
    fdx = fdx_en;
    if (rmii) begin
      spd   = fast_sel ? SPD_100 : SPD_10;
      unsup = gig_en;
    end else if (gig_en) begin
      spd   = SPD_1000;
      unsup = !fdx_en;
    end else begin
      spd   = fast_sel ? SPD_100 : SPD_10;
      unsup = !fast_sel;
    end
  end
endmodule

// File: rtl/rgmii_status_reg.sv
module rgmii_status_reg
  import rgmii_link_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  link_state_t nxt,
  output link_state_t cur,
  output logic        chg
);
  localparam link_state_t RESET_STATE = '{link: 1'b0, spd: SPD_10, fdx: 1'b0, unsup: 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= RESET_STATE;
      chg <= 1'b0;
    end else begin
      cur <= nxt;
      chg <= (nxt != cur);
    end
  end

  // R10
  chg_means_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> (cur != $past(cur)));

  // R10
  quiet_means_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chg |-> $stable(cur));
endmodule

// File: rtl/rgmii_link_resolver.sv
module rgmii_link_resolver
  import rgmii_link_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_ctl_rise,
  input  logic             rx_ctl_fall,
  input  logic [NIB_W-1:0] rxd,
  input  logic             ctl_inband_en,
  input  logic             ctl_gig_en,
  input  logic             ctl_fdx_en,
  input  logic             ctl_fast_sel,
  input  logic             rmii_sel,
  output logic             link_up,
  output logic [CODE_W-1:0] link_speed,
  output logic             full_duplex,
  output logic             status_chg,
  output logic             code_err,
  output logic             cfg_unsupported
);
  logic        ib_link, ib_fdx;
  speed_e      ib_spd;
  speed_e      fc_spd;
  logic        fc_fdx, fc_unsup;
  link_state_t nxt_state, cur_state;
  logic        base_link;

  rgmii_inband_capture cap_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_rise  (rx_ctl_rise),
    .ctl_fall  (rx_ctl_fall),
    .nib       (rxd),
    .dec_link  (ib_link),
    .dec_spd   (ib_spd),
    .dec_fdx   (ib_fdx),
    .rsvd_seen (code_err)
  );

  rgmii_forced_cfg frc_i (
    .gig_en   (ctl_gig_en),
    .fdx_en   (ctl_fdx_en),
    .fast_sel (ctl_fast_sel),
    .rmii     (rmii_sel),
    .spd      (fc_spd),
    .fdx      (fc_fdx),
    .unsup    (fc_unsup)
  );

  always_comb begin
    if (ctl_inband_en) begin
      base_link       = ib_link;
      nxt_state.spd   = ib_spd;
      nxt_state.fdx   = ib_fdx;
      nxt_state.unsup = rmii_sel || (ib_spd == SPD_1000 && !ib_fdx);
    end else begin
      base_link       = 1'b1;
      nxt_state.spd   = fc_spd;
      nxt_state.fdx   = fc_fdx;
      nxt_state.unsup = fc_unsup;
    end
    nxt_state.link = base_link && !nxt_state.unsup;
  end

  rgmii_status_reg out_i (
    .clk   (clk),
    .rst_n (rst_n),
    .nxt   (nxt_state),
    .cur   (cur_state),
    .chg   (status_chg)
  );

  assign link_up         = cur_state.link;
  assign link_speed      = cur_state.spd;
  assign full_duplex     = cur_state.fdx;
  assign cfg_unsupported = cur_state.unsup;

  // R9
  unsup_link_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_unsupported |-> !link_up);

  // R6
  gig_full_duplex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && link_speed == 2'b10) |-> full_duplex);
endmodule

// File: tb/rgmii_link_resolver_tb.sv
module rgmii_link_resolver_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_ctl_rise, rx_ctl_fall;
  logic [3:0] rxd;
  logic       ctl_inband_en, ctl_gig_en, ctl_fdx_en, ctl_fast_sel, rmii_sel;
  logic       link_up, full_duplex, status_chg, code_err, cfg_unsupported;
  logic [1:0] link_speed;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic       m_link, m_fdx;
  logic [1:0] m_spd;
  logic [4:0] prev_out;
  logic [4:0] exp_out;

  always #10 clk = ~clk;

  rgmii_link_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .rx_ctl_rise(rx_ctl_rise), .rx_ctl_fall(rx_ctl_fall),
    .rxd(rxd), .ctl_inband_en(ctl_inband_en), .ctl_gig_en(ctl_gig_en),
    .ctl_fdx_en(ctl_fdx_en), .ctl_fast_sel(ctl_fast_sel), .rmii_sel(rmii_sel),
    .link_up(link_up), .link_speed(link_speed), .full_duplex(full_duplex),
    .status_chg(status_chg), .code_err(code_err), .cfg_unsupported(cfg_unsupported)
  );

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Expected {unsup, link, spd[1:0], fdx} from the requirements
  function automatic logic [4:0] model();
    logic [1:0] s;
    logic       d, u, l;
    if (ctl_inband_en) begin
      s = m_spd; d = m_fdx;
      u = rmii_sel || (m_spd == 2'b10 && !m_fdx);
      l = m_link && !u;
    end else begin
      d = ctl_fdx_en;
      if (rmii_sel) begin
        s = ctl_fast_sel ? 2'b01 : 2'b00; u = ctl_gig_en;
      end else if (ctl_gig_en) begin
        s = 2'b10; u = !ctl_fdx_en;
      end else begin
        s = ctl_fast_sel ? 2'b01 : 2'b00; u = !ctl_fast_sel;
      end
      l = !u;
    end
    return {u, l, s, d};
  endfunction

  task automatic check_out(input string req);
    exp_out = model();
    check({req, " link"},   int'(link_up),         int'(exp_out[3]));
    check({req, " speed"},  int'(link_speed),      int'(exp_out[2:1]));
    check({req, " duplex"}, int'(full_duplex),     int'(exp_out[0]));
    check({req, " unsup"},  int'(cfg_unsupported), int'(exp_out[4]));
    check({req, " R10 strobe"}, int'(status_chg), int'(exp_out != prev_out));
    prev_out = exp_out;
  endtask

  task automatic send_nib(input logic [3:0] n);
    rxd = n;
    repeat (3) tick();
    if (n[2:1] != 2'b11) begin
      m_link = n[0]; m_spd = n[2:1]; m_fdx = n[3];
    end
    check("R5 code_err", int'(code_err), int'(n[2:1] == 2'b11));
    check_out("R3 nibble");
    tick();
    check("R10 strobe drops", int'(status_chg), 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_ctl_rise = 1'b0; rx_ctl_fall = 1'b0; rxd = 4'h0;
    ctl_inband_en = 1'b1; ctl_gig_en = 1'b0; ctl_fdx_en = 1'b0;
    ctl_fast_sel = 1'b0; rmii_sel = 1'b0;
    m_link = 1'b0; m_spd = 2'b00; m_fdx = 1'b0;
    repeat (3) tick();
    // R1 reset state
    check("R1 link",   int'(link_up), 0);
    check("R1 speed",  int'(link_speed), 0);
    check("R1 duplex", int'(full_duplex), 0);
    check("R1 strobe", int'(status_chg), 0);
    check("R1 code_err", int'(code_err), 0);
    check("R1 unsup",  int'(cfg_unsupported), 0);
    prev_out = 5'b0;
    rst_n = 1'b1;
    repeat (3) tick();
    check_out("R1 after release");

    // R3 / R5 / R9: sweep of all sixteen nibbles in in-band mode
    for (int n = 0; n < 16; n++) send_nib(4'(n));
    send_nib(4'b1011);

    // R4: single-cycle glitch
    rxd = 4'b0101; tick();
    rxd = 4'b1011; repeat (3) tick();
    check_out("R4 glitch ignored");

    // R2: nibble under active receive control
    rx_ctl_rise = 1'b1; rxd = 4'b1101; repeat (5) tick();
    check_out("R2 ctl rise busy");
    rx_ctl_rise = 1'b0; rx_ctl_fall = 1'b1; repeat (5) tick();
    check_out("R2 ctl fall busy");
    rx_ctl_fall = 1'b0; rxd = 4'b1011; repeat (3) tick();
    check_out("R2 back idle");

    // R3: exact latency
    rxd = 4'b1101; repeat (2) tick();
    check("R3 not yet", int'(link_speed), 1);
    tick();
    m_link = 1'b1; m_spd = 2'b10; m_fdx = 1'b1;
    check_out("R3 latency");

    // R6 R7 R8 R9: forced sweep
    ctl_inband_en = 1'b0;
    for (int c = 0; c < 16; c++) begin
      {rmii_sel, ctl_gig_en, ctl_fdx_en, ctl_fast_sel} = 4'(c);
      tick();
      check_out("R6 R7 R8 forced");
    end

    // R9: in-band on RMII
    ctl_inband_en = 1'b1; rmii_sel = 1'b1; tick();
    check_out("R9 inband rmii");

    // R11: in-band state retained across forced mode
    rmii_sel = 1'b0; tick();
    check_out("R11 retained");
    check("R11 speed", int'(link_speed), 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule